// File: doc/BRIEF.md
# Wired-to-Message Interrupt Node

This block collects up to a parameterised number of wired interrupt lines from peripherals. Each line that fires becomes one posted write on a memory-mapped bus, so no interrupt wire runs to the parent controller. The write goes to the translator register of an interrupt translation unit. Its address comes from a configuration input. The data word carries the pin's event ID, and a sideband output carries the pin's device ID.

Software programs the node through a 32-bit register slave with a 4 KiB window. The parent fabric places several nodes at consecutive 4 KiB bases and passes each node only the 12-bit offset. The window has three areas:
- a bit-per-pin sense-mode area,
- a word-per-pin vector area holding the event ID and device ID,
- a bit-per-pin write-one-to-release area.

Each pin, once sent, stays in service until software releases it. A round-robin arbiter chooses among pending pins. Only one message is outstanding on the request/acknowledge master port at any time.

Top module: `msg_irq_node`

## Requirements
- R1: After reset no message request is raised, every sense-mode word reads 0 and every vector word reads 0.
- R2: Sense-mode words read back as written. A vector word reads back its bits [21:0] as written with bits [31:22] as 0. Words of the release area always read 0. Read data appears one cycle after the read strobe.
- R3: A pin whose sense bit is 1 (active-high level) and whose input is high produces one message write. The write carries the pin's event ID (vector bits [21:12]) zero-extended on `msg_data`, its device ID (vector bits [11:0]) on `msg_devid`, and `trans_addr` on `msg_addr`.
- R4: A pin whose sense bit is 0 (rising edge) produces one message per rising edge. A line held high produces no further message.
- R5: A pin that has been sent is not sent again while in service. Writing 0 to its release bit leaves it in service.
- R6: After release, a level pin whose input is still high is sent again.
- R7: A rising edge on an edge pin while it is in service is remembered and sent after release. Without such an edge, release alone sends nothing.
- R8: When several pins are pending, they are served in increasing pin order starting after the pin served last, wrapping from the highest pin to pin 0.
- R9: `msg_req` stays high with `msg_data`, `msg_devid` and `msg_addr` unchanged until a cycle with `msg_ack` high. At most one message is outstanding at a time.
- R10: Pin p uses these locations: its sense bit is bit p%32 of the word at offset (p/32)*4; its vector word is at offset 0x200+4*p; its release bit is bit p%32 of the word at offset 0xA00+(p/32)*4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Wired interrupt lines, synchronous to clk |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset inside the node window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd_en` |
| trans_addr | input | 32 | Address of the translator register |
| msg_req | output | 1 | Message write request |
| msg_ack | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Event ID, zero-extended |
| msg_devid | output | 12 | Device ID sideband |

## Verification
The assertions assume that `msg_ack` is raised only while `msg_req` is high, and that `irq_in` is already synchronous to the clock. The bench raises the acknowledge only after it has seen the request at a falling edge. It drops the acknowledge one cycle later and changes interrupt lines only at falling edges. The hold-stability assertions also rely on `trans_addr` being quasi-static. The bench keeps it constant for the whole run.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int REG_AW    = 12;
  localparam int MODE_BASE = 32'h000;
  localparam int VEC_BASE  = 32'h200;
  localparam int REL_BASE  = 32'hA00;
  localparam int DEV_W     = 12;
  localparam int EVT_W     = 10;
  localparam int EVT_LSB   = DEV_W;
  localparam int VEC_W     = DEV_W + EVT_W;

  typedef enum logic [1:0] {RD_NONE, RD_MODE, RD_VEC} rd_sel_e;
  typedef enum logic [1:0] {ISS_IDLE, ISS_FETCH, ISS_SEND} iss_state_e;
endpackage

// File: rtl/msg_irq_regs.sv
module msg_irq_regs
  import msg_irq_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [REG_AW-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output logic [NUM_PINS-1:0]         mode_bits,
  output logic [NUM_PINS-1:0]         rel_pulse,
  input  logic [$clog2(NUM_PINS)-1:0] vec_raddr,
  output logic [VEC_W-1:0]            vec_rdata
);
  localparam int PIN_W     = $clog2(NUM_PINS);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int BANK_W    = NUM_WORDS * 32;

  logic [31:0] a32, voff, roff;
  logic        mode_hit, vec_hit, rel_hit;
  logic [WORD_W-1:0] midx, ridx;
  logic [PIN_W-1:0]  vidx;

  assign a32  = 32'(addr);
  assign voff = a32 - 32'(VEC_BASE);
  assign roff = a32 - 32'(REL_BASE);
  assign mode_hit = (a32 >= 32'(MODE_BASE)) && (a32 < 32'(MODE_BASE + 4*NUM_WORDS));
  assign vec_hit  = (a32 >= 32'(VEC_BASE))  && (a32 < 32'(VEC_BASE + 4*NUM_PINS));
  assign rel_hit  = (a32 >= 32'(REL_BASE))  && (a32 < 32'(REL_BASE + 4*NUM_WORDS));
  assign midx = a32[2 +: WORD_W];
  assign ridx = roff[2 +: WORD_W];
  assign vidx = voff[2 +: PIN_W];

  // sense-mode bank
  logic [BANK_W-1:0] mode_q;
  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (wr_en && mode_hit) mode_q[midx*32 +: 32] <= wdata;
  end
  assign mode_bits = mode_q[NUM_PINS-1:0];

  // release pulses, one cycle after the write
  logic [BANK_W-1:0] rel_q;
  always_ff @(posedge clk) begin
    if (rst) rel_q <= '0;
    else begin
      rel_q <= '0;
      if (wr_en && rel_hit) rel_q[ridx*32 +: 32] <= wdata;
    end
  end
  assign rel_pulse = rel_q[NUM_PINS-1:0];

  // vector storage: RAM without reset plus a per-word written flag
  logic [VEC_W-1:0]    vec_mem [NUM_PINS];
  logic [NUM_PINS-1:0] vec_written;
  always_ff @(posedge clk) begin
    if (wr_en && vec_hit) vec_mem[vidx] <= wdata[VEC_W-1:0];
  end
  always_ff @(posedge clk) begin
    if (rst) vec_written <= '0;
    else if (wr_en && vec_hit) vec_written[vidx] <= 1'b1;
  end

  // message-side read port
  logic [VEC_W-1:0] msg_word_q;
  logic             msg_ok_q;
  always_ff @(posedge clk) begin
    msg_word_q <= vec_mem[vec_raddr];
  end
  always_ff @(posedge clk) begin
    if (rst) msg_ok_q <= 1'b0;
    else     msg_ok_q <= vec_written[vec_raddr];
  end
  assign vec_rdata = msg_ok_q ? msg_word_q : '0;

  // software read port
  logic [VEC_W-1:0] sw_word_q;
  logic             sw_ok_q;
  logic [31:0]      mode_rd_q;
  rd_sel_e          sel_q;
  always_ff @(posedge clk) begin
    if (rd_en) sw_word_q <= vec_mem[vidx];
  end
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= RD_NONE;
      sw_ok_q   <= 1'b0;
      mode_rd_q <= '0;
    end else if (rd_en) begin
      sw_ok_q   <= vec_written[vidx];
      mode_rd_q <= mode_q[midx*32 +: 32];
      if (mode_hit)     sel_q <= RD_MODE;
      else if (vec_hit) sel_q <= RD_VEC;
      else              sel_q <= RD_NONE;
    end
  end

  always_comb begin
    unique case (sel_q)
      RD_MODE: rdata = mode_rd_q;
      RD_VEC:  rdata = sw_ok_q ? 32'(sw_word_q) : 32'h0;
      default: rdata = 32'h0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{wdata[31:VEC_W], voff[31:PIN_W+2], voff[1:0],
                         roff[31:WORD_W+2], roff[1:0], a32[31:WORD_W+2], a32[1:0]};
endmodule

// File: rtl/msg_irq_pins.sv
module msg_irq_pins #(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] mode_bits,
  input  logic [NUM_PINS-1:0] rel_pulse,
  input  logic [NUM_PINS-1:0] launch,
  output logic [NUM_PINS-1:0] pending,
  output logic [NUM_PINS-1:0] inserv
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic prev_q, edge_q, insv_q, rise;
    assign rise = irq_in[p] & ~prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        edge_q <= 1'b0;
        insv_q <= 1'b0;
      end else begin
        prev_q <= irq_in[p];
        // level pins keep no stale edge so a later mode change starts clean
        if (mode_bits[p]) edge_q <= 1'b0;
        else              edge_q <= rise | (edge_q & ~launch[p]);
        if (launch[p])         insv_q <= 1'b1;
        else if (rel_pulse[p]) insv_q <= 1'b0;
      end
    end
    assign pending[p] = ~insv_q & (mode_bits[p] ? irq_in[p] : edge_q);
    assign inserv[p]  = insv_q;
  end
endmodule

// File: rtl/msg_irq_rr.sv
module msg_irq_rr #(
  parameter int NUM_PINS = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PINS-1:0]         pending,
  input  logic                        advance,
  output logic                        gnt_valid,
  output logic [$clog2(NUM_PINS)-1:0] gnt_idx
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic [PIN_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst)          last_q <= PIN_W'(NUM_PINS - 1);
    else if (advance) last_q <= gnt_idx;
  end

  always_comb begin
    int cand;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      cand = int'(last_q) + 1 + i;
      if (cand >= NUM_PINS) cand = cand - NUM_PINS;
      if (!gnt_valid && pending[cand[PIN_W-1:0]]) begin
        gnt_valid = 1'b1;
        gnt_idx   = cand[PIN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/msg_irq_issue.sv
module msg_irq_issue
  import msg_irq_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        gnt_valid,
  input  logic [$clog2(NUM_PINS)-1:0] gnt_idx,
  output logic [NUM_PINS-1:0]         launch,
  output logic                        advance,
  output logic [$clog2(NUM_PINS)-1:0] vec_raddr,
  input  logic [VEC_W-1:0]            vec_rdata,
  input  logic [31:0]                 trans_addr,
  output logic                        msg_req,
  input  logic                        msg_ack,
  output logic [31:0]                 msg_addr,
  output logic [31:0]                 msg_data,
  output logic [DEV_W-1:0]            msg_devid
);
  iss_state_e state_q;

  always_comb begin
    launch = '0;
    if (state_q == ISS_IDLE && gnt_valid) launch[gnt_idx] = 1'b1;
  end
  assign advance   = |launch;
  assign vec_raddr = gnt_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ISS_IDLE;
      msg_req   <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_devid <= '0;
    end else begin
      unique case (state_q)
        ISS_IDLE:  if (gnt_valid) state_q <= ISS_FETCH;
        ISS_FETCH: begin
          msg_req   <= 1'b1;
          msg_addr  <= trans_addr;
          msg_data  <= 32'(vec_rdata[EVT_LSB +: EVT_W]);
          msg_devid <= vec_rdata[DEV_W-1:0];
          state_q   <= ISS_SEND;
        end
        ISS_SEND: if (msg_ack) begin
          msg_req <= 1'b0;
          state_q <= ISS_IDLE;
        end
        default: state_q <= ISS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_irq_node.sv
module msg_irq_node
  import msg_irq_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [31:0]         trans_addr,
  output logic                msg_req,
  input  logic                msg_ack,
  output logic [31:0]         msg_addr,
  output logic [31:0]         msg_data,
  output logic [DEV_W-1:0]    msg_devid
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic [NUM_PINS-1:0] mode_w, rel_w, launch_w, pending_w, inserv_w;
  logic [PIN_W-1:0]    gnt_idx_w, vec_raddr_w;
  logic                gnt_valid_w, advance_w;
  logic [VEC_W-1:0]    vec_rdata_w;

  msg_irq_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .mode_bits(mode_w), .rel_pulse(rel_w),
    .vec_raddr(vec_raddr_w), .vec_rdata(vec_rdata_w)
  );

  msg_irq_pins #(.NUM_PINS(NUM_PINS)) pins_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mode_bits(mode_w),
    .rel_pulse(rel_w), .launch(launch_w), .pending(pending_w), .inserv(inserv_w)
  );

  msg_irq_rr #(.NUM_PINS(NUM_PINS)) rr_i (
    .clk(clk), .rst(rst), .pending(pending_w), .advance(advance_w),
    .gnt_valid(gnt_valid_w), .gnt_idx(gnt_idx_w)
  );

  msg_irq_issue #(.NUM_PINS(NUM_PINS)) issue_i (
    .clk(clk), .rst(rst), .gnt_valid(gnt_valid_w), .gnt_idx(gnt_idx_w),
    .launch(launch_w), .advance(advance_w), .vec_raddr(vec_raddr_w),
    .vec_rdata(vec_rdata_w), .trans_addr(trans_addr),
    .msg_req(msg_req), .msg_ack(msg_ack), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_devid(msg_devid)
  );
endmodule

// File: rtl/msg_irq_node_chk.sv
module msg_irq_node_chk #(
  parameter int NUM_PINS = 128,
  parameter int EVT_W    = 10,
  parameter int DEV_W    = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                msg_req,
  input logic                msg_ack,
  input logic [31:0]         msg_addr,
  input logic [31:0]         msg_data,
  input logic [DEV_W-1:0]    msg_devid,
  input logic [NUM_PINS-1:0] launch,
  input logic [NUM_PINS-1:0] inserv
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !msg_req); // R1
  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> (msg_data[31:EVT_W] == '0)); // R3
  AST_NO_RESEND: assert property (@(posedge clk) disable iff (rst)
    (launch & inserv) == '0); // R5
  AST_ONE_PICK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(launch)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_req && !msg_ack |=> msg_req); // R9
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    msg_req && !msg_ack |=> $stable(msg_data) && $stable(msg_devid) && $stable(msg_addr)); // R9
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (|launch) |-> !msg_req); // R9
endmodule

bind msg_irq_node msg_irq_node_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst(rst), .msg_req(msg_req), .msg_ack(msg_ack),
  .msg_addr(msg_addr), .msg_data(msg_data), .msg_devid(msg_devid),
  .launch(launch_w), .inserv(inserv_w)
);

// File: tb/msg_irq_node_tb.sv
module msg_irq_node_tb_top;
  localparam int NP = 128;
  localparam logic [31:0] TADDR = 32'h0800_0040;

  logic        clk = 1'b0;
  logic        rst;
  logic [NP-1:0] irq_in;
  logic        reg_wr_en, reg_rd_en, msg_ack;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, trans_addr;
  logic        msg_req;
  logic [31:0] msg_addr, msg_data;
  logic [11:0] msg_devid;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  msg_irq_node #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trans_addr(trans_addr),
    .msg_req(msg_req), .msg_ack(msg_ack), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_devid(msg_devid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] vec(input int evt, input int dev);
    return (32'(evt) << 12) | 32'(dev);
  endfunction

  task automatic get_msg(input string tag, input int evt, input int dev, input int hold);
    bit seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (msg_req) begin seen = 1; break; end
      @(negedge clk);
    end
    check({tag, " request"}, 32'(seen), 32'd1);
    if (seen) begin
      check({tag, " data"}, msg_data, 32'(evt));
      check({tag, " devid"}, 32'(msg_devid), 32'(dev));
      check({tag, " addr"}, msg_addr, TADDR);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check({tag, " R9 held"}, {31'b0, msg_req}, 32'd1);
        check({tag, " R9 data stable"}, msg_data, 32'(evt));
      end
      msg_ack = 1'b1;
      @(negedge clk);
      msg_ack = 1'b0;
      check({tag, " R9 drop after ack"}, {31'b0, msg_req}, 32'd0);
    end
  endtask

  task automatic no_msg(input string tag, input int cycles);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_req) seen = 1;
    end
    check({tag, " no message"}, 32'(seen), 32'd0);
    if (seen) begin
      msg_ack = 1'b1;
      @(negedge clk);
      msg_ack = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 req after reset", {31'b0, msg_req}, 32'd0);
    rd(12'h004, d); check("R1 mode word", d, 32'h0);
    rd(12'h214, d); check("R1 vector word", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h004, 32'hA5A5_0F0F);
    rd(12'h004, d); check("R2 mode readback", d, 32'hA5A5_0F0F);
    wr(12'h21C, 32'hFFFF_FFFF);
    rd(12'h21C, d); check("R2 vector readback", d, 32'h003F_FFFF);
    rd(12'hA00, d); check("R2 release area reads 0", d, 32'h0);
    wr(12'h3FC, vec(127, 12'h17F));
    rd(12'h3FC, d); check("R10 last vector slot", d, vec(127, 12'h17F));
    wr(12'h004, 32'h0);
    rd(12'h004, d); check("R2 mode restore", d, 32'h0);
  endtask

  task automatic t_level();
    wr(12'h000, 32'h0000_0008);
    wr(12'h200 + 12'd12, vec(10'h155, 12'hABC));
    @(negedge clk); irq_in[3] = 1'b1;
    get_msg("R3 level pin", 10'h155, 12'hABC, 3);
    no_msg("R5 still in service", 20);
    wr(12'hA00, 32'h0);
    no_msg("R5 zero release ignored", 10);
    wr(12'hA00, 32'h0000_0008);
    get_msg("R6 level resend", 10'h155, 12'hABC, 0);
    @(negedge clk); irq_in[3] = 1'b0;
    wr(12'hA00, 32'h0000_0008);
    no_msg("R6 low after release", 10);
  endtask

  task automatic t_edge();
    wr(12'h200 + 12'd160, vec(40, 12'h128));
    @(negedge clk); irq_in[40] = 1'b1;
    get_msg("R4 edge pin", 40, 12'h128, 0);
    wr(12'hA04, 32'h0000_0100);
    no_msg("R7 release without new edge", 20);
    @(negedge clk); irq_in[40] = 1'b0;
    @(negedge clk); irq_in[40] = 1'b1;
    get_msg("R4 second edge", 40, 12'h128, 0);
    @(negedge clk); irq_in[40] = 1'b0;
    @(negedge clk); irq_in[40] = 1'b1;
    no_msg("R5 edge while in service", 10);
    wr(12'hA04, 32'h0000_0100);
    get_msg("R7 latched edge", 40, 12'h128, 0);
    wr(12'hA04, 32'h0000_0100);
    no_msg("R7 nothing left", 10);
    @(negedge clk); irq_in[40] = 1'b0;
  endtask

  task automatic t_round_robin();
    wr(12'h000, 32'h0000_0408);
    wr(12'h008, 32'h0000_0040);
    wr(12'h00C, 32'h8000_0000);
    wr(12'h200 + 12'd40,  vec(10, 12'h10A));
    wr(12'h200 + 12'd280, vec(70, 12'h146));
    @(negedge clk);
    irq_in[10] = 1'b1; irq_in[70] = 1'b1; irq_in[127] = 1'b1;
    get_msg("R8 first after pin 40", 70, 12'h146, 0);
    get_msg("R8 second", 127, 12'h17F, 0);
    get_msg("R8 wrap to low pin", 10, 12'h10A, 0);
    @(negedge clk);
    irq_in[10] = 1'b0; irq_in[70] = 1'b0; irq_in[127] = 1'b0;
    wr(12'hA00, 32'h0000_0400);
    wr(12'hA08, 32'h0000_0040);
    wr(12'hA0C, 32'h8000_0000);
    no_msg("R8 all served", 10);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; irq_in = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    reg_addr = '0; reg_wdata = '0; msg_ack = 1'b0; trans_addr = TADDR;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_round_robin();
    finish_run();
  end
endmodule